// File: doc/BRIEF.md
# Bus Ready-Timing Monitor

This block is a passive, synthesizable observer for one subordinate on an APB bus. It sees the select, enable and ready wires of that subordinate, a reference "data available" strobe from the subordinate's internals, and a flag that says whether another subordinate's access is running on the bus. It never drives the bus. It raises sticky error flags when the ready handshake breaks a timing or causality rule. It measures the wait states of every transfer and sorts each completion into a class.

Ready is only looked at on rising clock edges where both select and enable are high. Those are the access edges. A completion is an access edge with ready high. The wait count of a transfer is the number of access edges with ready low before its completion. Every counter stops at its all-ones value and does not wrap. The error flags clear only on reset.

Top module: `apb_ready_monitor`

## Requirements
- R1: After reset is asserted (active low), every error flag, `last_waits` and every counter read zero.
- R2: An access edge on which ready is unknown (X or Z) sets `err_x`. Known ready values never set it.
- R3: A completion sets `err_early` unless `data_ready` was high in some cycle of the same transfer, up to and including the completing edge, while select was high.
- R4: A completion on the first access edge of a transfer increments `cnt_zero` and sets `last_waits` to 0.
- R5: A completion after exactly one low-ready access edge increments `cnt_one` and sets `last_waits` to 1.
- R6: A completion after two or more low-ready access edges increments `cnt_multi` and sets `last_waits` to the number of those edges. The wait count restarts at the first access edge of each transfer.
- R7: Ready high outside an access edge (in a setup cycle, or while unselected) neither completes a transfer nor changes any class counter.
- R8: Each cycle with `other_busy` high and select low increments `cnt_idle`. If ready is not high in such a cycle, `err_idle` is set.
- R9: A setup cycle (select high, enable low) in the cycle right after a completion increments `cnt_b2b`.
- R10: Enable rising while select was low in the previous cycle sets `err_proto`.
- R11: Error flags stay set until reset. All counters saturate at all-ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; rising edges are sample points |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Select of the monitored subordinate |
| penable | input | 1 | Enable (access phase) |
| pready | input | 1 | Ready driven by the monitored subordinate |
| data_ready | input | 1 | Reference strobe: the subordinate's data is available |
| other_busy | input | 1 | Another subordinate's transfer is in progress |
| err_x | output | 1 | Sticky: ready unknown on an access edge |
| err_early | output | 1 | Sticky: completion without data_ready |
| err_proto | output | 1 | Sticky: access phase without setup |
| err_idle | output | 1 | Sticky: ready low while unselected during another access |
| last_waits | output | WAIT_W | Wait count of the last completed transfer |
| cnt_zero | output | CNT_W | Completions with no wait |
| cnt_one | output | CNT_W | Completions with one wait |
| cnt_multi | output | CNT_W | Completions with two or more waits |
| cnt_idle | output | CNT_W | Unselected cycles during another access |
| cnt_b2b | output | CNT_W | Back-to-back transfer starts |

## Verification
Transfers are driven with 0, 1, 2 and 4 wait states, which separates the three completion classes and shows that the wait count restarts for each transfer. Data-available timing is varied: present from setup, present only on the completing edge, and never present. This separates a legal late arrival from a true early completion. Ready is held high during setup and while unselected, which shows that only access edges count. Chained transfers with no idle gap, and a long run of them, cover back-to-back detection and counter saturation. Unselected cycles with ready high and then low, during another access, cover the default-ready rule.

// File: rtl/apb_rtm_pkg.sv
`timescale 1ns/1ps
package apb_rtm_pkg;
    // counted event classes; index into the event vector
    typedef enum logic [2:0] {
        EV_ZERO  = 3'd0,
        EV_ONE   = 3'd1,
        EV_MULTI = 3'd2,
        EV_IDLE  = 3'd3,
        EV_B2B   = 3'd4
    } ev_idx_e;

    localparam int NUM_EV = 5;

    typedef struct packed {
        logic x;
        logic early;
        logic proto;
        logic idle;
    } flags_t;
endpackage

// File: rtl/apb_rtm_track.sv
`timescale 1ns/1ps
module apb_rtm_track
    import apb_rtm_pkg::*;
#(
    parameter int WAIT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pready,
    input  logic              data_ready,
    input  logic              other_busy,
    output logic [NUM_EV-1:0] ev,
    output flags_t            err_ev,
    output logic [WAIT_W-1:0] last_waits
);
    localparam logic [WAIT_W-1:0] WAIT_TOP = '1;
    localparam logic [WAIT_W-1:0] WAIT_ONE = WAIT_W'(1);

    typedef struct packed {
        logic              sel_p;
        logic              en_p;
        logic              in_acc;
        logic              seen;
        logic              done_p;
        logic [WAIT_W-1:0] waits;
        logic [WAIT_W-1:0] last;
    } trk_t;

    trk_t trk_d, trk_q;

    logic              acc, first, rdy_known, rdy_hi, done, seen_now;
    logic [WAIT_W-1:0] cur;

    always_comb begin
        acc       = psel & penable;
        first     = acc & ~trk_q.in_acc;
        rdy_known = ~$isunknown(pready);
        rdy_hi    = rdy_known & pready;
        done      = acc & rdy_hi;
        cur       = first ? '0 : trk_q.waits;
        seen_now  = trk_q.seen | (psel & data_ready);

        trk_d        = trk_q;
        trk_d.sel_p  = psel;
        trk_d.en_p   = penable;
        trk_d.done_p = done;
        trk_d.in_acc = acc & ~done;
        trk_d.seen   = (done | ~psel) ? 1'b0 : seen_now;
        if (done) begin
            trk_d.waits = cur;
            trk_d.last  = cur;
        end else if (acc) begin
            trk_d.waits = (cur == WAIT_TOP) ? cur : cur + WAIT_ONE;
        end

        ev           = '0;
        ev[EV_ZERO]  = done & (cur == '0);
        ev[EV_ONE]   = done & (cur == WAIT_ONE);
        ev[EV_MULTI] = done & (cur > WAIT_ONE);
        ev[EV_IDLE]  = other_busy & ~psel;
        ev[EV_B2B]   = trk_q.done_p & psel & ~penable;

        err_ev.x     = acc & ~rdy_known;
        err_ev.early = done & ~seen_now;
        err_ev.proto = penable & ~trk_q.en_p & ~trk_q.sel_p;
        err_ev.idle  = other_busy & ~psel & ~rdy_hi;

        last_waits = trk_q.last;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end
endmodule

// File: rtl/apb_rtm_satcnt.sv
`timescale 1ns/1ps
module apb_rtm_satcnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] value
);
    localparam logic [W-1:0] TOP = '1;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && cnt_q != TOP) cnt_d = cnt_q + W'(1);
        value = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/apb_ready_monitor.sv
`timescale 1ns/1ps
module apb_ready_monitor
    import apb_rtm_pkg::*;
#(
    parameter int WAIT_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pready,
    input  logic              data_ready,
    input  logic              other_busy,
    output logic              err_x,
    output logic              err_early,
    output logic              err_proto,
    output logic              err_idle,
    output logic [WAIT_W-1:0] last_waits,
    output logic [CNT_W-1:0]  cnt_zero,
    output logic [CNT_W-1:0]  cnt_one,
    output logic [CNT_W-1:0]  cnt_multi,
    output logic [CNT_W-1:0]  cnt_idle,
    output logic [CNT_W-1:0]  cnt_b2b
);
    logic [NUM_EV-1:0] ev;
    flags_t            err_ev;
    flags_t            flg_d, flg_q;
    logic [CNT_W-1:0]  cnt_arr [NUM_EV];

    apb_rtm_track #(.WAIT_W(WAIT_W)) i_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .psel       (psel),
        .penable    (penable),
        .pready     (pready),
        .data_ready (data_ready),
        .other_busy (other_busy),
        .ev         (ev),
        .err_ev     (err_ev),
        .last_waits (last_waits)
    );

    for (genvar g = 0; g < NUM_EV; g++) begin : g_cnt
        apb_rtm_satcnt #(.W(CNT_W)) i_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (ev[g]),
            .value (cnt_arr[g])
        );
    end

    // sticky flags: set by events, cleared only by reset
    always_comb begin
        flg_d = flg_q | err_ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flg_q <= '0;
        else        flg_q <= flg_d;
    end

    assign err_x     = flg_q.x;
    assign err_early = flg_q.early;
    assign err_proto = flg_q.proto;
    assign err_idle  = flg_q.idle;
    assign cnt_zero  = cnt_arr[EV_ZERO];
    assign cnt_one   = cnt_arr[EV_ONE];
    assign cnt_multi = cnt_arr[EV_MULTI];
    assign cnt_idle  = cnt_arr[EV_IDLE];
    assign cnt_b2b   = cnt_arr[EV_B2B];
endmodule

// File: rtl/apb_rtm_check.sv
`timescale 1ns/1ps
module apb_rtm_check #(
    parameter int WAIT_W = 8,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              psel,
    input logic              penable,
    input logic              pready,
    input logic              data_ready,
    input logic              other_busy,
    input logic              err_x,
    input logic              err_early,
    input logic              err_proto,
    input logic              err_idle,
    input logic [WAIT_W-1:0] last_waits,
    input logic [CNT_W-1:0]  cnt_zero,
    input logic [CNT_W-1:0]  cnt_one,
    input logic [CNT_W-1:0]  cnt_multi,
    input logic [CNT_W-1:0]  cnt_idle,
    input logic [CNT_W-1:0]  cnt_b2b
);
    assert_x_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && $isunknown(pready)) |=> err_x);

    assert_early_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && pready && !data_ready && $past(psel && !penable && !data_ready))
        |=> err_early);

    assert_zero_class_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && pready && $past(psel && !penable))
        |=> (last_waits == '0) && (cnt_zero == $past(cnt_zero) + CNT_W'(1) || (&$past(cnt_zero))));

    assert_idle_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (other_busy && !psel && !pready) |=> err_idle);

    assert_proto_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(penable) && !$past(psel)) |=> err_proto);

    assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !($fell(err_x) || $fell(err_early) || $fell(err_proto) || $fell(err_idle)));

    assert_no_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_zero >= $past(cnt_zero)) && (cnt_b2b >= $past(cnt_b2b)) && (cnt_idle >= $past(cnt_idle)));
endmodule

bind apb_ready_monitor apb_rtm_check #(.WAIT_W(WAIT_W), .CNT_W(CNT_W)) i_chk (.*);

// File: tb/test_apb_ready_monitor.sv
`timescale 1ns/1ps
module test_apb_ready_monitor;
    localparam int WAIT_W = 8;
    localparam int CNT_W  = 8;

    logic clk = 1'b0;
    logic rst_n, psel, penable, pready, data_ready, other_busy;
    logic err_x, err_early, err_proto, err_idle;
    logic [WAIT_W-1:0] last_waits;
    logic [CNT_W-1:0]  cnt_zero, cnt_one, cnt_multi, cnt_idle, cnt_b2b;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 1'b0;

    always #10 clk = ~clk;

    apb_ready_monitor #(.WAIT_W(WAIT_W), .CNT_W(CNT_W)) i_apb_ready_monitor (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pready(pready),
        .data_ready(data_ready), .other_busy(other_busy),
        .err_x(err_x), .err_early(err_early), .err_proto(err_proto), .err_idle(err_idle),
        .last_waits(last_waits), .cnt_zero(cnt_zero), .cnt_one(cnt_one),
        .cnt_multi(cnt_multi), .cnt_idle(cnt_idle), .cnt_b2b(cnt_b2b)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // drm: 0 never, 1 from setup, 2 only on completing edge; sp: ready during setup
    task automatic xfer(input int waits, input int drm, input bit sp = 1'b0);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pready = sp; data_ready = (drm == 1);
        for (int i = 0; i < waits; i++) begin
            @(negedge clk);
            penable = 1'b1; pready = 1'b0;
        end
        @(negedge clk);
        penable = 1'b1; pready = 1'b1;
        if (drm == 2) data_ready = 1'b1;
    endtask

    task automatic idle(input int n, input bit busy, input bit rdy);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            psel = 1'b0; penable = 1'b0; data_ready = 1'b0;
            other_busy = busy; pready = rdy;
        end
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; data_ready = 1'b0;
        other_busy = 1'b0; pready = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state(input string tag);
        check({tag, " err_x"},      int'(err_x), 0);
        check({tag, " err_early"},  int'(err_early), 0);
        check({tag, " err_proto"},  int'(err_proto), 0);
        check({tag, " err_idle"},   int'(err_idle), 0);
        check({tag, " last_waits"}, int'(last_waits), 0);
        check({tag, " counters"},
              int'(cnt_zero) + int'(cnt_one) + int'(cnt_multi) + int'(cnt_idle) + int'(cnt_b2b), 0);
    endtask

    task automatic t_zero_wait();
        xfer(0, 1); idle(1, 0, 0);
        check("R4 cnt_zero", int'(cnt_zero), 1);
        check("R4 last_waits", int'(last_waits), 0);
        check("R3 no early error with data from setup", int'(err_early), 0);
    endtask

    task automatic t_one_wait();
        xfer(1, 1); idle(1, 0, 0);
        check("R5 cnt_one", int'(cnt_one), 1);
        check("R5 last_waits", int'(last_waits), 1);
    endtask

    task automatic t_multi_wait();
        xfer(4, 1); idle(1, 0, 0);
        check("R6 cnt_multi", int'(cnt_multi), 1);
        check("R6 last_waits four", int'(last_waits), 4);
    endtask

    task automatic t_ignore_outside();
        xfer(2, 1, 1'b1); idle(1, 0, 0);
        check("R7 setup ready ignored, cnt_multi", int'(cnt_multi), 2);
        check("R7 setup ready ignored, last_waits", int'(last_waits), 2);
        check("R7 setup ready ignored, cnt_zero", int'(cnt_zero), 1);
        idle(3, 0, 1);
        check("R7 unselected ready ignored", int'(cnt_zero) + int'(cnt_one), 2);
    endtask

    task automatic t_late_data();
        xfer(2, 2); idle(1, 0, 0);
        check("R3 data on completing edge is legal", int'(err_early), 0);
        check("R6 wait count restarts", int'(last_waits), 2);
        check("R6 cnt_multi", int'(cnt_multi), 3);
    endtask

    task automatic t_back_to_back();
        xfer(0, 1); xfer(1, 1); xfer(0, 1); idle(1, 0, 0);
        check("R9 cnt_b2b", int'(cnt_b2b), 2);
        check("R4 cnt_zero after chain", int'(cnt_zero), 3);
        check("R5 cnt_one after chain", int'(cnt_one), 2);
    endtask

    task automatic t_idle();
        idle(5, 1, 1);
        check("R8 cnt_idle", int'(cnt_idle), 5);
        check("R8 ready high keeps err_idle clear", int'(err_idle), 0);
        check("R2 known ready keeps err_x clear", int'(err_x), 0);
        idle(1, 1, 0);
        check("R8 cnt_idle", int'(cnt_idle), 6);
        check("R8 ready low sets err_idle", int'(err_idle), 1);
    endtask

    task automatic t_proto();
        check("R10 err_proto clear before", int'(err_proto), 0);
        @(negedge clk);
        psel = 1'b1; penable = 1'b1; pready = 1'b1; data_ready = 1'b1;
        idle(1, 0, 0);
        check("R10 access without setup", int'(err_proto), 1);
        check("R4 cnt_zero", int'(cnt_zero), 4);
    endtask

    task automatic t_early();
        xfer(1, 0); idle(1, 0, 0);
        check("R3 completion without data", int'(err_early), 1);
        check("R5 cnt_one", int'(cnt_one), 3);
        idle(3, 0, 0);
        check("R11 flags stay set",
              int'(err_early) + int'(err_proto) + int'(err_idle), 3);
    endtask

    task automatic t_saturate();
        for (int i = 0; i < 300; i++) xfer(0, 1);
        idle(1, 0, 0);
        check("R11 cnt_zero saturates", int'(cnt_zero), 255);
        check("R11 cnt_b2b saturates", int'(cnt_b2b), 255);
        check("R11 no errors from legal chain", int'(err_early) + int'(err_proto), 0);
    endtask

    initial begin
        rst_n = 1'b0; psel = 1'b0; penable = 1'b0; pready = 1'b0;
        data_ready = 1'b0; other_busy = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state("R1 reset");
        t_zero_wait();
        t_one_wait();
        t_multi_wait();
        t_ignore_outside();
        t_late_data();
        t_back_to_back();
        t_idle();
        t_proto();
        t_early();
        do_reset();
        @(negedge clk);
        t_reset_state("R1 R11 reset clears");
        t_saturate();
        if (!ended) begin
            ended = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule